// File: doc/BRIEF.md
# MDIO Management Register Slave

This block is the management-side slave of an Ethernet transceiver. It listens on the serial management line, clocked by the station's management clock, recognises read and write frames sent to its strapped 5-bit station address, and serves a small register bank. The bidirectional data line is split into a sampled input, a registered output value and a registered output enable, so that pad logic outside the block builds the tri-state driver.

The bank holds three registers. The control register has writable mode bits and a self-clearing soft-reset bit. The status register reports fixed capabilities and a link bit that latches low. The error register collects sticky event flags that clear when they are read. All other register addresses read as zero and ignore writes.

After a frame to this slave has completed, the next frame may begin after a single idle bit instead of a full preamble. The status register advertises this capability.

Top module: `mdio_mgmt_slave`

## Requirements
- R1: After reset `mdio_oe` and `mdio_o` are low. Register 0 reads 0x3000, register 1 reads 0x0041 (link bit 2 low), and the error register (address 18) reads 0x0000.
- R2: A frame is decoded from bits sampled on the rising edge of `mdc`. The bits are: at least 32 ones, start bits 0 then 1, opcode 10 = read or 01 = write, 5 address bits of the station, 5 register-address bits, 2 turnaround bits and 16 data bits. All fields are sent most significant bit first.
- R3: On a read, `mdio_oe` stays low during the first turnaround bit. It then goes high with `mdio_o` = 0 for the second turnaround bit. The 16 data bits follow, most significant first, and `mdio_oe` drops after the last data bit. Each output change is registered on a rising `mdc` edge.
- R4: Once a frame addressed to this slave has completed, a following frame is accepted when a single 1 precedes its start bits. Status bit 6 reads 1 to advertise this.
- R5: A frame whose station address differs from `phy_addr` causes no drive on the line and no register change. The slave skips that frame's 18 remaining bits.
- R6: An invalid start pair (00) or an invalid opcode (00 or 11) abandons the frame. The slave then needs a full run of 32 ones again, so frames with a 1-bit or 31-bit preamble are ignored until then.
- R7: Control bits 14, 13, 12 and 8 are read/write. All other control bits read as 0, whatever was written.
- R8: Writing 1 to control bit 15 restores the control register to 0x3000 and clears the link latch and the error flags. Bit 15 always reads 0.
- R9: Status bit 2 goes to 0 on any cycle in which `link_up` is low. It stays 0 until status is read, even if the link returns. The read after that returns the current link state.
- R10: Error bit 1 latches `err_in[1]` (invalid symbol) and bit 0 latches `err_in[0]` (false carrier). A read returns the latched flags and then clears them, except for events present in the cycle of the read.
- R11: Writes to the status register, the error register or an unimplemented address have no effect. Reads of unimplemented addresses return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| mdc | input | 1 | Management clock; input sampled and outputs registered on its rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| phy_addr | input | 5 | Strapped station address of this slave |
| link_up | input | 1 | Raw link indication from the link monitor |
| err_in | input | 2 | Error events: bit 1 invalid symbol, bit 0 false carrier |
| mdio_i | input | 1 | Sampled management data line |
| mdio_o | output | 1 | Value to drive on the management data line |
| mdio_oe | output | 1 | Output enable for the management data line |

## Verification
On every cycle, the assertions check the following. The line is driven only during read frames. The drive begins with a zero turnaround bit and is released only from the last data bit. A skipped frame never drives the line. The link latch follows a low link in the next cycle, error flags survive every cycle without a clearing read or soft reset, and a soft reset leaves the bank at its defaults. Other behaviour only the bench scenarios can show, because it concerns whole frames and their order. This covers the exact bit pattern returned on each read, the hold-low of the link bit until it is read, clearing of flags by a read, masking of reserved control bits, and the rejection of frames with the wrong address, opcode, start bits or preamble length.

// File: rtl/mdio_slv_pkg.sv
package mdio_slv_pkg;

    localparam int MDIO_DW    = 16;
    localparam int MDIO_PHY_W = 5;
    localparam int MDIO_REG_W = 5;
    localparam int MDIO_ERR_W = 2;

    localparam logic [1:0] OP_RD = 2'b10;
    localparam logic [1:0] OP_WR = 2'b01;

    localparam logic [MDIO_REG_W-1:0] CTRL_ADDR = 5'd0;
    localparam logic [MDIO_REG_W-1:0] STAT_ADDR = 5'd1;

    localparam int CTRL_RST_BIT  = 15;
    localparam int STAT_LINK_BIT = 2;
    // bit 6: frames without preamble accepted, bit 0: extended registers present
    localparam logic [MDIO_DW-1:0] STAT_FIXED = 16'h0041;

    typedef enum logic [2:0] {
        S_HUNT,
        S_START,
        S_OP,
        S_ADDR,
        S_TURN,
        S_DATA,
        S_SKIP
    } fr_state_e;

endpackage

// File: rtl/mdio_frame_ctl.sv
module mdio_frame_ctl
    import mdio_slv_pkg::*;
#(
    parameter int PRE_LEN = 32,
    parameter int DATA_W  = MDIO_DW,
    parameter int PHY_W   = MDIO_PHY_W,
    parameter int REG_W   = MDIO_REG_W
) (
    input  logic              mdc,
    input  logic              rst_n,
    input  logic [PHY_W-1:0]  phy_addr,
    input  logic              mdio_i,
    output logic              mdio_o,
    output logic              mdio_oe,
    output logic              rd_req,
    output logic [REG_W-1:0]  rd_addr,
    input  logic [DATA_W-1:0] rd_data,
    output logic              wr_req,
    output logic [REG_W-1:0]  wr_addr,
    output logic [DATA_W-1:0] wr_data
);

    localparam int ADR_BITS = PHY_W + REG_W;
    localparam int CNT_W    = $clog2(DATA_W + 2);
    localparam int ONE_W    = $clog2(PRE_LEN + 1);
    localparam logic [ONE_W-1:0] ONES_SAT  = ONE_W'(PRE_LEN);
    localparam logic [CNT_W-1:0] ADR_LAST  = CNT_W'(ADR_BITS - 1);
    localparam logic [CNT_W-1:0] DATA_LAST = CNT_W'(DATA_W - 1);
    localparam logic [CNT_W-1:0] SKIP_LAST = CNT_W'(DATA_W + 1);

    typedef struct packed {
        fr_state_e          st;
        logic [CNT_W-1:0]   cnt;
        logic [ONE_W-1:0]   ones;
        logic               sup_ok;
        logic               is_rd;
        logic [DATA_W-2:0]  sh;
        logic [REG_W-1:0]   reg_a;
        logic [DATA_W-1:0]  rd_sh;
        logic               out;
        logic               oe;
    } fr_t;

    fr_t q, d;

    always_comb begin
        d       = q;
        rd_req  = 1'b0;
        wr_req  = 1'b0;
        rd_addr = {q.sh[REG_W-2:0], mdio_i};
        wr_addr = q.reg_a;
        wr_data = {q.sh, mdio_i};
        case (q.st)
            S_HUNT: begin
                if (mdio_i) begin
                    if (q.ones != ONES_SAT) d.ones = q.ones + 1'b1;
                end else begin
                    if (q.ones == ONES_SAT || (q.sup_ok && q.ones != '0))
                        d.st = S_START;
                    d.ones = '0;
                end
            end
            S_START: begin
                d.cnt = '0;
                if (mdio_i) d.st = S_OP;
                else begin
                    d.st     = S_HUNT;
                    d.sup_ok = 1'b0;
                end
            end
            S_OP: begin
                d.sh  = {q.sh[DATA_W-3:0], mdio_i};
                d.cnt = q.cnt + 1'b1;
                if (q.cnt == CNT_W'(1)) begin
                    d.cnt = '0;
                    if ({q.sh[0], mdio_i} == OP_RD) begin
                        d.st    = S_ADDR;
                        d.is_rd = 1'b1;
                    end else if ({q.sh[0], mdio_i} == OP_WR) begin
                        d.st    = S_ADDR;
                        d.is_rd = 1'b0;
                    end else begin
                        d.st     = S_HUNT;
                        d.sup_ok = 1'b0;
                    end
                end
            end
            S_ADDR: begin
                d.sh  = {q.sh[DATA_W-3:0], mdio_i};
                d.cnt = q.cnt + 1'b1;
                if (q.cnt == ADR_LAST) begin
                    d.cnt = '0;
                    if (q.sh[ADR_BITS-2:REG_W-1] == phy_addr) begin
                        d.st    = S_TURN;
                        d.reg_a = rd_addr;
                        if (q.is_rd) begin
                            rd_req  = 1'b1;
                            d.rd_sh = rd_data;
                        end
                    end else begin
                        d.st = S_SKIP;
                    end
                end
            end
            S_TURN: begin
                d.cnt = q.cnt + 1'b1;
                if (q.cnt == '0) begin
                    if (q.is_rd) begin
                        d.oe  = 1'b1;
                        d.out = 1'b0;
                    end
                end else begin
                    d.st  = S_DATA;
                    d.cnt = '0;
                    if (q.is_rd) begin
                        d.out   = q.rd_sh[DATA_W-1];
                        d.rd_sh = {q.rd_sh[DATA_W-2:0], 1'b0};
                    end
                end
            end
            S_DATA: begin
                d.sh  = {q.sh[DATA_W-3:0], mdio_i};
                d.cnt = q.cnt + 1'b1;
                if (q.cnt == DATA_LAST) begin
                    d.st     = S_HUNT;
                    d.oe     = 1'b0;
                    d.out    = 1'b0;
                    d.sup_ok = 1'b1;
                    d.ones   = '0;
                    d.cnt    = '0;
                    wr_req   = !q.is_rd;
                end else if (q.is_rd) begin
                    d.out   = q.rd_sh[DATA_W-1];
                    d.rd_sh = {q.rd_sh[DATA_W-2:0], 1'b0};
                end
            end
            S_SKIP: begin
                d.cnt = q.cnt + 1'b1;
                if (q.cnt == SKIP_LAST) begin
                    d.st   = S_HUNT;
                    d.ones = '0;
                    d.cnt  = '0;
                end
            end
            default: d.st = S_HUNT;
        endcase
    end

    always_ff @(posedge mdc or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: S_HUNT, default: '0};
        end else begin
            q <= d;
        end
    end

    assign mdio_o  = q.out;
    assign mdio_oe = q.oe;

    // the line is only ever driven while a read frame is in progress
    assert_drive_only_read_R3: assert property (@(posedge mdc) disable iff (!rst_n)
        mdio_oe |-> q.is_rd);

    // the first driven bit is the zero of the second turnaround bit
    assert_turn_zero_R3: assert property (@(posedge mdc) disable iff (!rst_n)
        $rose(mdio_oe) |-> !mdio_o);

    // release happens only when the last data bit has been sent
    assert_release_end_R3: assert property (@(posedge mdc) disable iff (!rst_n)
        $fell(mdio_oe) |-> $past(q.st == S_DATA));

    // frames for another station never cause a drive
    assert_skip_silent_R5: assert property (@(posedge mdc) disable iff (!rst_n)
        (q.st == S_SKIP) |-> !mdio_oe);

endmodule

// File: rtl/mdio_reg_bank.sv
module mdio_reg_bank
    import mdio_slv_pkg::*;
#(
    parameter int DATA_W = MDIO_DW,
    parameter int REG_W  = MDIO_REG_W,
    parameter int ERR_W  = MDIO_ERR_W,
    parameter logic [DATA_W-1:0] CTRL_DEF   = 16'h3000,
    parameter logic [DATA_W-1:0] CTRL_WMASK = 16'h7100,
    parameter logic [REG_W-1:0]  ERR_ADDR   = 5'd18
) (
    input  logic              mdc,
    input  logic              rst_n,
    input  logic              link_up,
    input  logic [ERR_W-1:0]  err_in,
    input  logic              rd_req,
    input  logic [REG_W-1:0]  rd_addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic              wr_req,
    input  logic [REG_W-1:0]  wr_addr,
    input  logic [DATA_W-1:0] wr_data
);

    localparam logic [DATA_W-1:0] RST_MASK  = DATA_W'(1) << CTRL_RST_BIT;
    localparam logic [DATA_W-1:0] WR_ALLOW  = CTRL_WMASK & ~RST_MASK;

    typedef struct packed {
        logic [DATA_W-1:0] ctrl;
        logic              link;
        logic [ERR_W-1:0]  err;
    } bank_t;

    bank_t q, d;
    logic  rd_stat, rd_err, soft_rst;

    always_comb begin
        d        = q;
        rd_stat  = rd_req && (rd_addr == STAT_ADDR);
        rd_err   = rd_req && (rd_addr == ERR_ADDR);
        soft_rst = wr_req && (wr_addr == CTRL_ADDR) && wr_data[CTRL_RST_BIT];

        if (rd_addr == CTRL_ADDR)
            rd_data = q.ctrl;
        else if (rd_addr == STAT_ADDR)
            rd_data = STAT_FIXED | (DATA_W'(q.link) << STAT_LINK_BIT);
        else if (rd_addr == ERR_ADDR)
            rd_data = DATA_W'(q.err);
        else
            rd_data = '0;

        d.link = link_up & (q.link | rd_stat);
        d.err  = rd_err ? err_in : (q.err | err_in);

        if (soft_rst) begin
            d.ctrl = CTRL_DEF;
            d.link = 1'b0;
            d.err  = '0;
        end else if (wr_req && wr_addr == CTRL_ADDR) begin
            d.ctrl = wr_data & WR_ALLOW;
        end
    end

    always_ff @(posedge mdc or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{ctrl: CTRL_DEF, default: '0};
        end else begin
            q <= d;
        end
    end

    // a low link is captured in the next cycle
    assert_link_latch_low_R9: assert property (@(posedge mdc) disable iff (!rst_n)
        !link_up |=> !q.link);

    // flags persist unless a clearing read or a soft reset occurs
    assert_err_sticky_R10: assert property (@(posedge mdc) disable iff (!rst_n)
        (!rd_err && !soft_rst) |=> ((q.err & $past(q.err)) == $past(q.err)));

    // soft reset leaves the bank at its defaults
    assert_soft_reset_R8: assert property (@(posedge mdc) disable iff (!rst_n)
        soft_rst |=> (q.ctrl == CTRL_DEF && !q.link && q.err == '0));

    // a register access is either a read or a write, never both
    assert_one_access_R2: assert property (@(posedge mdc) disable iff (!rst_n)
        !(rd_req && wr_req));

endmodule

// File: rtl/mdio_mgmt_slave.sv
module mdio_mgmt_slave
    import mdio_slv_pkg::*;
#(
    parameter int PRE_LEN = 32,
    parameter logic [MDIO_DW-1:0]    CTRL_DEF   = 16'h3000,
    parameter logic [MDIO_DW-1:0]    CTRL_WMASK = 16'h7100,
    parameter logic [MDIO_REG_W-1:0] ERR_ADDR   = 5'd18
) (
    input  logic                  mdc,
    input  logic                  rst_n,
    input  logic [MDIO_PHY_W-1:0] phy_addr,
    input  logic                  link_up,
    input  logic [MDIO_ERR_W-1:0] err_in,
    input  logic                  mdio_i,
    output logic                  mdio_o,
    output logic                  mdio_oe
);

    logic                  rd_req, wr_req;
    logic [MDIO_REG_W-1:0] rd_addr, wr_addr;
    logic [MDIO_DW-1:0]    rd_data, wr_data;

    mdio_frame_ctl #(
        .PRE_LEN (PRE_LEN),
        .DATA_W  (MDIO_DW),
        .PHY_W   (MDIO_PHY_W),
        .REG_W   (MDIO_REG_W)
    ) i_frame (
        .mdc      (mdc),
        .rst_n    (rst_n),
        .phy_addr (phy_addr),
        .mdio_i   (mdio_i),
        .mdio_o   (mdio_o),
        .mdio_oe  (mdio_oe),
        .rd_req   (rd_req),
        .rd_addr  (rd_addr),
        .rd_data  (rd_data),
        .wr_req   (wr_req),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data)
    );

    mdio_reg_bank #(
        .DATA_W     (MDIO_DW),
        .REG_W      (MDIO_REG_W),
        .ERR_W      (MDIO_ERR_W),
        .CTRL_DEF   (CTRL_DEF),
        .CTRL_WMASK (CTRL_WMASK),
        .ERR_ADDR   (ERR_ADDR)
    ) i_bank (
        .mdc     (mdc),
        .rst_n   (rst_n),
        .link_up (link_up),
        .err_in  (err_in),
        .rd_req  (rd_req),
        .rd_addr (rd_addr),
        .rd_data (rd_data),
        .wr_req  (wr_req),
        .wr_addr (wr_addr),
        .wr_data (wr_data)
    );

endmodule

// File: tb/test_mdio_mgmt_slave.sv
module test_mdio_mgmt_slave;

    logic       mdc = 1'b0;
    logic       rst_n = 1'b0;
    logic       mdio_i = 1'b1;
    logic       link_up = 1'b1;
    logic [1:0] err_in = 2'b00;
    logic [4:0] phy = 5'd9;
    logic       mdio_o, mdio_oe;

    int checks = 0;
    int errors = 0;

    // behavioural model of the register bank
    logic [15:0] m_ctrl = 16'h3000;
    logic        m_link = 1'b0;
    logic [1:0]  m_err  = 2'b00;
    int          ev_rd  = -1;
    logic        ev_wr  = 1'b0;
    logic [4:0]  ev_wa  = '0;
    logic [15:0] ev_wd  = '0;

    always #5 mdc = ~mdc;

    mdio_mgmt_slave i_mdio_mgmt_slave (
        .mdc      (mdc),
        .rst_n    (rst_n),
        .phy_addr (phy),
        .link_up  (link_up),
        .err_in   (err_in),
        .mdio_i   (mdio_i),
        .mdio_o   (mdio_o),
        .mdio_oe  (mdio_oe)
    );

    task automatic chk(input logic [15:0] act, input logic [15:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] model_read(input logic [4:0] a);
        if (a == 5'd0)  return m_ctrl;
        if (a == 5'd1)  return 16'h0041 | (16'(m_link) << 2);
        if (a == 5'd18) return {14'd0, m_err};
        return 16'h0000;
    endfunction

    // one bit period: drive, clock, advance the model, compare outputs
    task automatic tick(input logic b, input logic eoe, input logic eo, input string tag);
        logic rs, re;
        @(negedge mdc);
        mdio_i = b;
        @(posedge mdc);
        rs = (ev_rd == 1);
        re = (ev_rd == 18);
        m_link = link_up & (m_link | rs);
        m_err  = re ? err_in : (m_err | err_in);
        if (ev_wr && ev_wa == 5'd0) begin
            if (ev_wd[15]) begin
                m_ctrl = 16'h3000;
                m_link = 1'b0;
                m_err  = 2'b00;
            end else begin
                m_ctrl = ev_wd & 16'h7100;
            end
        end
        ev_rd = -1;
        ev_wr = 1'b0;
        #2;
        chk({15'd0, mdio_oe}, {15'd0, eoe}, {tag, " oe R3"});
        if (eoe) chk({15'd0, mdio_o}, {15'd0, eo}, {tag, " data R3"});
    endtask

    task automatic frame(input int pre, input logic [1:0] st, input logic [1:0] op,
                         input logic [4:0] pa, input logic [4:0] ra, input logic [15:0] wd,
                         input logic acc, input string tag);
        logic hit, rd;
        logic [15:0] ev;
        hit = acc && (pa == phy);
        rd  = (op == 2'b10);
        ev  = '0;
        for (int i = 0; i < pre; i++) tick(1'b1, 1'b0, 1'b0, tag);
        tick(st[1], 1'b0, 1'b0, tag);
        tick(st[0], 1'b0, 1'b0, tag);
        tick(op[1], 1'b0, 1'b0, tag);
        tick(op[0], 1'b0, 1'b0, tag);
        for (int i = 4; i >= 0; i--) tick(pa[i], 1'b0, 1'b0, tag);
        for (int i = 4; i >= 1; i--) tick(ra[i], 1'b0, 1'b0, tag);
        if (hit && rd) begin
            ev    = model_read(ra);
            ev_rd = int'(ra);
        end
        tick(ra[0], 1'b0, 1'b0, tag);
        if (hit && rd) begin
            tick(1'b1, 1'b1, 1'b0, tag);
            tick(1'b1, 1'b1, ev[15], tag);
            for (int k = 0; k < 15; k++) tick(1'b1, 1'b1, ev[14-k], tag);
            tick(1'b1, 1'b0, 1'b0, tag);
        end else begin
            tick(1'b1, 1'b0, 1'b0, tag);
            tick(1'b0, 1'b0, 1'b0, tag);
            for (int k = 15; k >= 1; k--) tick(wd[k], 1'b0, 1'b0, tag);
            if (hit) begin
                ev_wr = 1'b1;
                ev_wa = ra;
                ev_wd = wd;
            end
            tick(wd[0], 1'b0, 1'b0, tag);
        end
    endtask

    task automatic rd_frame(input int pre, input logic [4:0] ra, input string tag);
        frame(pre, 2'b01, 2'b10, phy, ra, 16'h0000, 1'b1, tag);
    endtask

    task automatic wr_frame(input int pre, input logic [4:0] ra, input logic [15:0] wd,
                            input string tag);
        frame(pre, 2'b01, 2'b01, phy, ra, wd, 1'b1, tag);
    endtask

    task automatic idle(input int n, input string tag);
        for (int i = 0; i < n; i++) tick(1'b1, 1'b0, 1'b0, tag);
    endtask

    initial begin
        repeat (3) @(posedge mdc);
        #2;
        chk({15'd0, mdio_oe}, 16'd0, "R1 reset oe");
        chk({15'd0, mdio_o},  16'd0, "R1 reset data");
        @(negedge mdc);
        rst_n = 1'b1;

        // R1 / R2: defaults through ordinary read frames
        rd_frame(32, 5'd0,  "R1 R2 control default");
        rd_frame(32, 5'd1,  "R1 R2 status default");
        rd_frame(32, 5'd18, "R1 R2 error default");

        // R9: latch-low link bit
        rd_frame(32, 5'd1, "R9 link reported up");
        link_up = 1'b0;
        idle(3, "R9 link drop");
        link_up = 1'b1;
        idle(3, "R9 link back");
        rd_frame(32, 5'd1, "R9 held low until read");
        rd_frame(32, 5'd1, "R9 relatched after read");

        // R7: writable control bits and reserved bits
        wr_frame(32, 5'd0, 16'h7FFF, "R7 write all but reset");
        rd_frame(32, 5'd0, "R7 masked readback");
        wr_frame(32, 5'd0, 16'h0100, "R7 single bit write");
        rd_frame(32, 5'd0, "R7 single bit readback");

        // R10: sticky, clear-on-read error flags
        err_in = 2'b10;
        idle(1, "R10 symbol event");
        err_in = 2'b00;
        idle(2, "R10 quiet");
        rd_frame(32, 5'd18, "R10 symbol flag set");
        rd_frame(32, 5'd18, "R10 cleared by read");
        err_in = 2'b01;
        idle(1, "R10 carrier event");
        err_in = 2'b00;
        rd_frame(32, 5'd18, "R10 carrier flag set");

        // R8: self-clearing soft reset
        wr_frame(32, 5'd0, 16'h4000, "R8 set mode");
        err_in = 2'b11;
        idle(1, "R8 both events");
        err_in = 2'b00;
        rd_frame(32, 5'd1, "R8 latch link");
        wr_frame(32, 5'd0, 16'h8000, "R8 soft reset");
        rd_frame(32, 5'd0, "R8 control restored");
        rd_frame(32, 5'd18, "R8 flags cleared");
        rd_frame(32, 5'd1, "R8 link latch cleared");

        // R11: writes without effect, unimplemented reads
        wr_frame(32, 5'd1,  16'hFFFF, "R11 write status");
        wr_frame(32, 5'd18, 16'hFFFF, "R11 write error reg");
        wr_frame(32, 5'd7,  16'hFFFF, "R11 write unimplemented");
        rd_frame(32, 5'd7,  "R11 unimplemented reads zero");
        rd_frame(32, 5'd18, "R11 error reg unchanged");
        rd_frame(32, 5'd1,  "R11 status unchanged");
        rd_frame(32, 5'd0,  "R11 control unchanged");

        // R5: frames for another station
        frame(32, 2'b01, 2'b01, phy ^ 5'd1, 5'd0, 16'h4000, 1'b1, "R5 foreign write");
        frame(32, 2'b01, 2'b10, phy ^ 5'd4, 5'd0, 16'h0000, 1'b1, "R5 foreign read");
        rd_frame(32, 5'd0, "R5 control untouched");

        // R4: preamble suppression after a completed own frame
        rd_frame(1, 5'd1, "R4 single idle read status");
        wr_frame(1, 5'd0, 16'h1000, "R4 single idle write");
        rd_frame(1, 5'd0, "R4 single idle readback");

        // R6: rejected frames need a full preamble again
        frame(32, 2'b01, 2'b11, phy, 5'd0, 16'h4100, 1'b0, "R6 bad opcode");
        frame(1,  2'b01, 2'b01, phy, 5'd0, 16'h4100, 1'b0, "R6 short preamble after abort");
        tick(1'b0, 1'b0, 1'b0, "R6 zero before 31 ones");
        frame(31, 2'b01, 2'b01, phy, 5'd0, 16'h4100, 1'b0, "R6 31 ones");
        frame(32, 2'b00, 2'b01, phy, 5'd0, 16'h4100, 1'b0, "R6 bad start");
        rd_frame(32, 5'd0, "R6 control unchanged");
        idle(4, "R6 trailing idle");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #1000000;
        errors++;
        $display("FAIL watchdog R2: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule